// File: doc/BRIEF.md
# Subarray Scan-Table Builder

This block holds, for every row of a detector array, a mask with one bit per scan column. A set bit means that column is converted when the row is read out. Software-side logic asks for rectangular windows in pixel coordinates. The block checks the alignment and range of each window, maps it to scan columns of a fixed pixel pitch, and then ORs the window's column span into each covered row, one row per clock.

Alongside the masks the block keeps a few running figures: how many bits are set in each row, how many are set in the whole table, the lowest and highest row holding any bit, and the lowest and highest column used in each row. A readout sequencer uses a combinational read port to fetch a row's mask, its bit count, its column bounds and a single-position hit flag. A one-cycle clear command empties the table.

Top module: `scan_table_builder`

## Requirements
- R1: A window is rejected unless its x origin and its width are both multiples of 16 pixels, the width is 16 or more, and x plus width is no larger than 512 pixels (32 columns of 16 pixels).
- R2: A window is rejected unless its y origin and its height are both multiples of 4, y is below 32, and y plus height is no larger than 32 rows. A height of zero is legal.
- R3: A rejected window changes nothing in the table. It raises done_o with ok_o low on the cycle after the request edge, and busy_o never rises for it.
- R4: An accepted window covers scan columns x/16 through (x+width)/16-1. Scan column c is held in mask bit 31-c, so column 0 is the most significant bit. Rows y through y+height-1 are covered.
- R5: An accepted window of height h>0 keeps busy_o high for exactly h cycles, writing one row per cycle, and done_o rises with ok_o high on the cycle after the last row is written. An accepted window of height 0 gives done_o with ok_o high one cycle after the request and writes nothing.
- R6: The per-row count and the total count go up only for bits that were clear before. Re-covering a set bit adds nothing.
- R7: On an empty table, the first row written loads both the lowest and the highest active row. Later writes only move these bounds outward. An empty table reports 0 for both.
- R8: The first write into an empty row loads that row's lowest and highest column from the window. Later writes only move these bounds outward. An empty row reports 0 for both.
- R9: A read at row index 32 or above returns a zero mask, a zero count and zero column bounds. rd_hit_o is 0 whenever the row or the column index (32 or above) is out of range.
- R10: clr_i zeroes every mask, count and bound and stops any window in progress, and no done_o is ever raised for the stopped window.
- R11: add_req_i is ignored while busy_o is high. The window then being written completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Empty the table (one cycle) |
| add_req_i | input | 1 | Request to add the window on the win_* inputs |
| win_x_i | input | 10 | Window x origin in pixels |
| win_w_i | input | 10 | Window width in pixels |
| win_y_i | input | 6 | Window y origin in rows |
| win_h_i | input | 6 | Window height in rows |
| busy_o | output | 1 | A window is being written |
| done_o | output | 1 | One-cycle pulse: request finished |
| ok_o | output | 1 | Result of the latest finished request (1 = accepted) |
| rd_row_i | input | 6 | Row index for the read port |
| rd_col_i | input | 6 | Column index for the hit flag |
| rd_mask_o | output | 32 | Column mask of the addressed row |
| rd_cnt_o | output | 6 | Set-bit count of the addressed row |
| rd_min_col_o | output | 5 | Lowest column used in the addressed row |
| rd_max_col_o | output | 5 | Highest column used in the addressed row |
| rd_hit_o | output | 1 | Addressed position is marked for conversion |
| total_o | output | 11 | Set-bit count over the whole table |
| min_row_o | output | 5 | Lowest row holding any bit |
| max_row_o | output | 5 | Highest row holding any bit |

## Verification
Two cases are hard to reach from the ports because each needs a command to land while a window is still being written. The first is a second add request during a write. The second is a clear in the middle of a tall window. To reach both, the stimulus starts a tall window and drives the next command a fixed number of falling edges later. It then confirms through the read port that the interfering window left no trace, or that the table is empty, and the scoreboard flags any done pulse it was not told to expect. Overlap between two windows is also set up on purpose, so that counts which would be wrong if a set bit were counted twice can be read back and compared.

// File: rtl/scan_tbl_pkg.sv
package scan_tbl_pkg;
    // Default geometry: 32 scan columns of 16 pixels, 32 rows, groups of 4 rows.
    localparam int DEF_COLS        = 32;
    localparam int DEF_ROWS        = 32;
    localparam int DEF_PIX_PER_COL = 16;
    localparam int DEF_ROW_GROUP   = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // True when v is an exact multiple of m (m > 0).
    function automatic logic is_multiple(input int v, input int m);
        return (v % m) == 0;
    endfunction
endpackage

// File: rtl/scan_win_check.sv
module scan_win_check
    import scan_tbl_pkg::*;
#(
    parameter int NUM_COLS    = DEF_COLS,
    parameter int NUM_ROWS    = DEF_ROWS,
    parameter int PIX_PER_COL = DEF_PIX_PER_COL,
    parameter int ROW_GROUP   = DEF_ROW_GROUP,
    parameter int PXW         = 10,
    parameter int RYW         = 6,
    parameter int CIW         = 5
) (
    input  logic [PXW-1:0] win_x_i,
    input  logic [PXW-1:0] win_w_i,
    input  logic [RYW-1:0] win_y_i,
    input  logic [RYW-1:0] win_h_i,
    output logic           ok_o,
    output logic [CIW-1:0] col_lo_o,
    output logic [CIW-1:0] col_hi_o
);
    localparam int ARR_PIX = NUM_COLS * PIX_PER_COL;

    int x_v, w_v, y_v, h_v;
    logic horiz_ok, vert_ok;

    always_comb begin
        x_v = int'(win_x_i);
        w_v = int'(win_w_i);
        y_v = int'(win_y_i);
        h_v = int'(win_h_i);
        horiz_ok = is_multiple(x_v, PIX_PER_COL) && is_multiple(w_v, PIX_PER_COL)
                   && (w_v >= PIX_PER_COL) && ((x_v + w_v) <= ARR_PIX);
        vert_ok  = is_multiple(y_v, ROW_GROUP) && is_multiple(h_v, ROW_GROUP)
                   && (y_v < NUM_ROWS) && ((y_v + h_v) <= NUM_ROWS);
        ok_o     = horiz_ok && vert_ok;
        col_lo_o = CIW'(x_v / PIX_PER_COL);
        col_hi_o = CIW'(((x_v + w_v) / PIX_PER_COL) - 1);
    end
endmodule

// File: rtl/scan_row_seq.sv
module scan_row_seq
    import scan_tbl_pkg::*;
#(
    parameter int RYW = 6,
    parameter int CIW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic           add_req_i,
    input  logic           win_ok_i,
    input  logic [CIW-1:0] col_lo_i,
    input  logic [CIW-1:0] col_hi_i,
    input  logic [RYW-1:0] row_y_i,
    input  logic [RYW-1:0] row_h_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           ok_o,
    output logic           wr_en_o,
    output logic [RYW-1:0] wr_row_o,
    output logic [CIW-1:0] wr_col_lo_o,
    output logic [CIW-1:0] wr_col_hi_o
);
    seq_state_e     state_q;
    logic [RYW-1:0] cur_q, last_q;
    logic [CIW-1:0] lo_q, hi_q;
    logic           done_q, ok_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (add_req_i) begin
                        if (!win_ok_i) begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b0;
                        end else if (row_h_i == '0) begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b1;
                        end else begin
                            state_q <= SEQ_RUN;
                            cur_q   <= row_y_i;
                            last_q  <= row_y_i + row_h_i - 1'b1;
                            lo_q    <= col_lo_i;
                            hi_q    <= col_hi_i;
                        end
                    end
                end
                SEQ_RUN: begin
                    cur_q <= cur_q + 1'b1;
                    if (cur_q == last_q) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                        ok_q    <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q == SEQ_RUN);
    assign done_o      = done_q;
    assign ok_o        = ok_q;
    assign wr_en_o     = busy_o;
    assign wr_row_o    = cur_q;
    assign wr_col_lo_o = lo_q;
    assign wr_col_hi_o = hi_q;

    assert_busy_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !done_o);
    assert_ignore_req_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && add_req_i && !clr_i) |=> ($stable(last_q) && $stable(lo_q) && $stable(hi_q)));
    assert_clear_idle_R10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (!busy_o && !done_o));
    assert_reject_quick_R3: assert property (@(posedge clk) disable iff (rst)
        (add_req_i && !busy_o && !clr_i && !win_ok_i) |=> (done_o && !ok_o && !busy_o));
endmodule

// File: rtl/scan_row_store.sv
module scan_row_store
    import scan_tbl_pkg::*;
#(
    parameter int NUM_COLS = DEF_COLS,
    parameter int NUM_ROWS = DEF_ROWS,
    parameter int RYW      = 6,
    parameter int CIW      = 5,
    parameter int RIW      = 5,
    parameter int CNTW     = 6,
    parameter int TOTW     = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                wr_en_i,
    input  logic [RYW-1:0]      wr_row_i,
    input  logic [CIW-1:0]      wr_col_lo_i,
    input  logic [CIW-1:0]      wr_col_hi_i,
    input  logic [RYW-1:0]      rd_row_i,
    input  logic [CIW:0]        rd_col_i,
    output logic [NUM_COLS-1:0] rd_mask_o,
    output logic [CNTW-1:0]     rd_cnt_o,
    output logic [CIW-1:0]      rd_min_col_o,
    output logic [CIW-1:0]      rd_max_col_o,
    output logic                rd_hit_o,
    output logic [TOTW-1:0]     total_o,
    output logic [RIW-1:0]      min_row_o,
    output logic [RIW-1:0]      max_row_o
);
    logic [NUM_COLS-1:0] mask_a [NUM_ROWS];
    logic [CNTW-1:0]     cnt_a  [NUM_ROWS];
    logic [CIW-1:0]      minc_a [NUM_ROWS];
    logic [CIW-1:0]      maxc_a [NUM_ROWS];

    logic [NUM_COLS-1:0] span;
    logic [NUM_COLS-1:0] sel_old;
    logic [CNTW-1:0]     add_cnt;
    logic                row_in;
    logic [RIW-1:0]      wr_idx;

    // Column c maps to bit NUM_COLS-1-c (column 0 is the MSB).
    always_comb begin
        for (int i = 0; i < NUM_COLS; i++) begin
            span[NUM_COLS-1-i] = (CIW'(i) >= wr_col_lo_i) && (CIW'(i) <= wr_col_hi_i);
        end
    end

    assign row_in  = wr_en_i && (wr_row_i < RYW'(NUM_ROWS));
    assign wr_idx  = wr_row_i[RIW-1:0];
    assign sel_old = row_in ? mask_a[wr_idx] : '0;
    assign add_cnt = CNTW'($countones(span & ~sel_old));

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        logic [NUM_COLS-1:0] mask_q;
        logic [CNTW-1:0]     cnt_q;
        logic [CIW-1:0]      minc_q, maxc_q;
        logic                hit;

        assign hit = row_in && (wr_row_i == RYW'(r));

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                mask_q <= '0;
                cnt_q  <= '0;
                minc_q <= '0;
                maxc_q <= '0;
            end else if (hit) begin
                mask_q <= mask_q | span;
                cnt_q  <= cnt_q + add_cnt;
                if (cnt_q == '0) begin
                    minc_q <= wr_col_lo_i;
                    maxc_q <= wr_col_hi_i;
                end else begin
                    if (wr_col_lo_i < minc_q) minc_q <= wr_col_lo_i;
                    if (wr_col_hi_i > maxc_q) maxc_q <= wr_col_hi_i;
                end
            end
        end

        assign mask_a[r] = mask_q;
        assign cnt_a[r]  = cnt_q;
        assign minc_a[r] = minc_q;
        assign maxc_a[r] = maxc_q;

        assert_col_order_R8: assert property (@(posedge clk) disable iff (rst)
            (cnt_q != '0) |-> (minc_q <= maxc_q));
    end

    logic [TOTW-1:0] total_q;
    logic [RIW-1:0]  min_row_q, max_row_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            total_q   <= '0;
            min_row_q <= '0;
            max_row_q <= '0;
        end else if (row_in) begin
            total_q <= total_q + TOTW'(add_cnt);
            if (total_q == '0) begin
                min_row_q <= wr_idx;
                max_row_q <= wr_idx;
            end else begin
                if (wr_idx < min_row_q) min_row_q <= wr_idx;
                if (wr_idx > max_row_q) max_row_q <= wr_idx;
            end
        end
    end

    // Read port.
    logic           rd_row_ok, rd_col_ok;
    logic [CIW-1:0] bit_idx;

    always_comb begin
        rd_row_ok = rd_row_i < RYW'(NUM_ROWS);
        rd_col_ok = rd_col_i < (CIW+1)'(NUM_COLS);
        bit_idx   = CIW'(NUM_COLS - 1) - rd_col_i[CIW-1:0];
        if (rd_row_ok) begin
            rd_mask_o    = mask_a[rd_row_i[RIW-1:0]];
            rd_cnt_o     = cnt_a[rd_row_i[RIW-1:0]];
            rd_min_col_o = minc_a[rd_row_i[RIW-1:0]];
            rd_max_col_o = maxc_a[rd_row_i[RIW-1:0]];
        end else begin
            rd_mask_o    = '0;
            rd_cnt_o     = '0;
            rd_min_col_o = '0;
            rd_max_col_o = '0;
        end
        rd_hit_o = rd_row_ok && rd_col_ok && rd_mask_o[bit_idx];
    end

    assign total_o   = total_q;
    assign min_row_o = min_row_q;
    assign max_row_o = max_row_q;

    assert_total_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !clr_i) |=> $stable(total_q));
    assert_total_grow_R6: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (total_q >= $past(total_q)));
    assert_row_order_R7: assert property (@(posedge clk) disable iff (rst)
        (total_q != '0) |-> (min_row_q <= max_row_q));
    assert_clear_empty_R10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (total_q == '0));
endmodule

// File: rtl/scan_table_builder.sv
module scan_table_builder
    import scan_tbl_pkg::*;
#(
    parameter int NUM_COLS    = DEF_COLS,
    parameter int NUM_ROWS    = DEF_ROWS,
    parameter int PIX_PER_COL = DEF_PIX_PER_COL,
    parameter int ROW_GROUP   = DEF_ROW_GROUP,
    localparam int PXW  = $clog2(NUM_COLS * PIX_PER_COL) + 1,
    localparam int RYW  = $clog2(NUM_ROWS) + 1,
    localparam int CIW  = $clog2(NUM_COLS),
    localparam int RIW  = $clog2(NUM_ROWS),
    localparam int CNTW = $clog2(NUM_COLS + 1),
    localparam int TOTW = $clog2(NUM_COLS * NUM_ROWS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                add_req_i,
    input  logic [PXW-1:0]      win_x_i,
    input  logic [PXW-1:0]      win_w_i,
    input  logic [RYW-1:0]      win_y_i,
    input  logic [RYW-1:0]      win_h_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                ok_o,
    input  logic [RYW-1:0]      rd_row_i,
    input  logic [CIW:0]        rd_col_i,
    output logic [NUM_COLS-1:0] rd_mask_o,
    output logic [CNTW-1:0]     rd_cnt_o,
    output logic [CIW-1:0]      rd_min_col_o,
    output logic [CIW-1:0]      rd_max_col_o,
    output logic                rd_hit_o,
    output logic [TOTW-1:0]     total_o,
    output logic [RIW-1:0]      min_row_o,
    output logic [RIW-1:0]      max_row_o
);
    logic           win_ok;
    logic [CIW-1:0] col_lo, col_hi;
    logic           wr_en;
    logic [RYW-1:0] wr_row;
    logic [CIW-1:0] wr_lo, wr_hi;

    scan_win_check #(
        .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .PIX_PER_COL(PIX_PER_COL),
        .ROW_GROUP(ROW_GROUP), .PXW(PXW), .RYW(RYW), .CIW(CIW)
    ) u_check (
        .win_x_i(win_x_i), .win_w_i(win_w_i), .win_y_i(win_y_i), .win_h_i(win_h_i),
        .ok_o(win_ok), .col_lo_o(col_lo), .col_hi_o(col_hi)
    );

    scan_row_seq #(.RYW(RYW), .CIW(CIW)) u_seq (
        .clk(clk), .rst(rst), .clr_i(clr_i), .add_req_i(add_req_i),
        .win_ok_i(win_ok), .col_lo_i(col_lo), .col_hi_i(col_hi),
        .row_y_i(win_y_i), .row_h_i(win_h_i),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
        .wr_en_o(wr_en), .wr_row_o(wr_row), .wr_col_lo_o(wr_lo), .wr_col_hi_o(wr_hi)
    );

    scan_row_store #(
        .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .RYW(RYW), .CIW(CIW),
        .RIW(RIW), .CNTW(CNTW), .TOTW(TOTW)
    ) u_store (
        .clk(clk), .rst(rst), .clr_i(clr_i),
        .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_col_lo_i(wr_lo), .wr_col_hi_i(wr_hi),
        .rd_row_i(rd_row_i), .rd_col_i(rd_col_i),
        .rd_mask_o(rd_mask_o), .rd_cnt_o(rd_cnt_o),
        .rd_min_col_o(rd_min_col_o), .rd_max_col_o(rd_max_col_o), .rd_hit_o(rd_hit_o),
        .total_o(total_o), .min_row_o(min_row_o), .max_row_o(max_row_o)
    );
endmodule

// File: tb/test_scan_table_builder.sv
`timescale 1ns/1ps
module test_scan_table_builder;
    localparam int COLS = 32;
    localparam int ROWS = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        add_req_i = 1'b0;
    logic [9:0]  win_x_i = '0, win_w_i = '0;
    logic [5:0]  win_y_i = '0, win_h_i = '0;
    logic        busy_o, done_o, ok_o;
    logic [5:0]  rd_row_i = '0;
    logic [5:0]  rd_col_i = '0;
    logic [31:0] rd_mask_o;
    logic [5:0]  rd_cnt_o;
    logic [4:0]  rd_min_col_o, rd_max_col_o;
    logic        rd_hit_o;
    logic [10:0] total_o;
    logic [4:0]  min_row_o, max_row_o;

    scan_table_builder i_scan_table_builder (
        .clk(clk), .rst(rst), .clr_i(clr_i), .add_req_i(add_req_i),
        .win_x_i(win_x_i), .win_w_i(win_w_i), .win_y_i(win_y_i), .win_h_i(win_h_i),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
        .rd_row_i(rd_row_i), .rd_col_i(rd_col_i),
        .rd_mask_o(rd_mask_o), .rd_cnt_o(rd_cnt_o),
        .rd_min_col_o(rd_min_col_o), .rd_max_col_o(rd_max_col_o), .rd_hit_o(rd_hit_o),
        .total_o(total_o), .min_row_o(min_row_o), .max_row_o(max_row_o)
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Reference model of the table.
    logic [31:0] m_mask [ROWS];
    int m_cnt [ROWS];
    int m_minc [ROWS];
    int m_maxc [ROWS];
    int m_total, m_minr, m_maxr;

    // Scoreboard of expected done results.
    bit sb_q [$];

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int r = 0; r < ROWS; r++) begin
            m_mask[r] = '0; m_cnt[r] = 0; m_minc[r] = 0; m_maxc[r] = 0;
        end
        m_total = 0; m_minr = 0; m_maxr = 0;
    endtask

    function automatic bit window_legal(input int x, input int w, input int y, input int h);
        return (x % 16 == 0) && (w % 16 == 0) && (w >= 16) && (x + w <= 512)
            && (y % 4 == 0) && (h % 4 == 0) && (y < ROWS) && (y + h <= ROWS);
    endfunction

    task automatic model_add(input int x, input int w, input int y, input int h);
        for (int r = y; r < y + h; r++) begin
            for (int c = x / 16; c < (x + w) / 16; c++) begin
                if (!m_mask[r][31-c]) begin
                    if (m_total == 0) begin m_minr = r; m_maxr = r; end
                    else begin
                        if (r < m_minr) m_minr = r;
                        if (r > m_maxr) m_maxr = r;
                    end
                    if (m_cnt[r] == 0) begin m_minc[r] = c; m_maxc[r] = c; end
                    else begin
                        if (c < m_minc[r]) m_minc[r] = c;
                        if (c > m_maxc[r]) m_maxc[r] = c;
                    end
                    m_mask[r][31-c] = 1'b1;
                    m_cnt[r]++;
                    m_total++;
                end
            end
        end
    endtask

    // Compare every row and the global figures through the read port.
    task automatic check_table(input string req);
        int bad_rows;
        bad_rows = 0;
        for (int r = 0; r < ROWS; r++) begin
            rd_row_i = 6'(r);
            #0.1;
            if (rd_mask_o != m_mask[r] || int'(rd_cnt_o) != m_cnt[r]
                || int'(rd_min_col_o) != m_minc[r] || int'(rd_max_col_o) != m_maxc[r]) begin
                bad_rows++;
                $display("FAIL %s row %0d: actual mask %h cnt %0d cols %0d..%0d expected mask %h cnt %0d cols %0d..%0d",
                         req, r, rd_mask_o, rd_cnt_o, rd_min_col_o, rd_max_col_o,
                         m_mask[r], m_cnt[r], m_minc[r], m_maxc[r]);
            end
        end
        n_tests++;
        if (bad_rows != 0) n_fail++;
        check({req, " total"}, int'(total_o), m_total);
        check({req, " min row"}, int'(min_row_o), m_minr);
        check({req, " max row"}, int'(max_row_o), m_maxr);
    endtask

    // Driver: issue a window and push the expected verdict.
    task automatic add_win(input string req, input int x, input int w, input int y, input int h);
        bit legal;
        int k;
        legal = window_legal(x, w, y, h);
        sb_q.push_back(legal);
        @(negedge clk);
        win_x_i = 10'(x); win_w_i = 10'(w); win_y_i = 6'(y); win_h_i = 6'(h);
        add_req_i = 1'b1;
        @(negedge clk);
        add_req_i = 1'b0;
        k = 1;
        while (!done_o && k < 200) begin
            @(negedge clk);
            k++;
        end
        check({req, " cycles to done"}, k, (legal && h > 0) ? h + 1 : 1);
        if (legal) model_add(x, w, y, h);
    endtask

    // Monitor: compare each done pulse against the scoreboard.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R10 unexpected done: actual 1 expected 0");
            end else begin
                bit e;
                e = sb_q.pop_front();
                check("R1/R2 verdict", int'(ok_o), int'(e));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R7, R5)
        check("R5 reset busy", int'(busy_o), 0);
        check("R5 reset done", int'(done_o), 0);
        check_table("R7 reset");

        // Basic window: cols 2..4, rows 4..11 (R4, R5)
        add_win("R5 win A", 32, 48, 4, 8);
        rd_row_i = 6'd4; #0.1;
        check("R4 col 2..4 mask bits", int'(rd_mask_o), 32'h3800_0000);
        check_table("R4 after A");

        // Overlapping window: cols 3..6, rows 8..11 (R6, R8)
        add_win("R6 win B", 48, 64, 8, 4);
        rd_row_i = 6'd9; #0.1;
        check("R6 no double count", int'(rd_cnt_o), 5);
        check("R8 min col", int'(rd_min_col_o), 2);
        check("R8 max col", int'(rd_max_col_o), 6);
        check_table("R6 after B");

        // Rejects (R1, R2, R3)
        add_win("R1 x misaligned", 8, 16, 0, 4);
        add_win("R1 zero width", 0, 0, 0, 4);
        add_win("R1 past right edge", 480, 48, 0, 4);
        add_win("R2 y misaligned", 0, 16, 2, 4);
        add_win("R2 h misaligned", 0, 16, 0, 3);
        add_win("R2 past bottom", 0, 16, 28, 8);
        check_table("R3 after rejects");

        // Zero-height window accepted (R5)
        add_win("R5 zero height", 0, 16, 0, 0);
        check_table("R5 zero height table");

        // Full-width window on the last group (R4, R8, R1 boundary)
        add_win("R1 full width", 0, 512, 28, 4);
        rd_row_i = 6'd28; rd_col_i = 6'd0; #0.1;
        check("R4 col 0 hit", int'(rd_hit_o), 1);
        check("R4 full mask", int'(rd_mask_o == 32'hFFFF_FFFF), 1);
        rd_col_i = 6'd31; #0.1;
        check("R4 col 31 hit", int'(rd_hit_o), 1);
        check_table("R8 full width");

        // Out-of-range reads (R9)
        rd_col_i = 6'd32; #0.1;
        check("R9 col out of range hit", int'(rd_hit_o), 0);
        rd_row_i = 6'd32; rd_col_i = 6'd0; #0.1;
        check("R9 row 32 mask", int'(rd_mask_o), 0);
        check("R9 row 32 cnt", int'(rd_cnt_o), 0);
        check("R9 row 32 hit", int'(rd_hit_o), 0);
        rd_row_i = 6'd45; #0.1;
        check("R9 row 45 mask", int'(rd_mask_o), 0);

        // Lower minimum row (R7)
        add_win("R7 lower rows", 0, 16, 0, 4);
        check("R7 min row", int'(min_row_o), 0);
        check_table("R7 after lower");

        // Clear (R10)
        @(negedge clk); clr_i = 1'b1;
        @(negedge clk); clr_i = 1'b0;
        model_clear();
        check_table("R10 clear");

        // First set after clear loads bounds (R7, R8)
        add_win("R7 first after clear", 256, 32, 16, 4);
        check("R7 min row reload", int'(min_row_o), 16);
        check("R7 max row reload", int'(max_row_o), 19);
        rd_row_i = 6'd17; #0.1;
        check("R8 col reload min", int'(rd_min_col_o), 16);
        check("R8 col reload max", int'(rd_max_col_o), 17);

        // Request during busy is ignored (R11)
        begin
            int k;
            sb_q.push_back(1'b1);
            @(negedge clk);
            win_x_i = 10'd0; win_w_i = 10'd16; win_y_i = 6'd0; win_h_i = 6'd8;
            add_req_i = 1'b1;
            @(negedge clk);
            add_req_i = 1'b0;
            check("R11 busy during window", int'(busy_o), 1);
            @(negedge clk);
            win_x_i = 10'd256; win_w_i = 10'd16; win_y_i = 6'd20; win_h_i = 6'd4;
            add_req_i = 1'b1;
            @(negedge clk);
            add_req_i = 1'b0;
            k = 3;
            while (!done_o && k < 200) begin @(negedge clk); k++; end
            check("R11 window length unchanged", k, 9);
            model_add(0, 16, 0, 8);
            repeat (3) @(negedge clk);
            check("R11 no second window", int'(busy_o), 0);
            check_table("R11 after ignored request");
        end

        // Clear during a window aborts it without done (R10)
        @(negedge clk);
        win_x_i = 10'd0; win_w_i = 10'd64; win_y_i = 6'd0; win_h_i = 6'd16;
        add_req_i = 1'b1;
        @(negedge clk);
        add_req_i = 1'b0;
        repeat (3) @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R10 abort busy", int'(busy_o), 0);
        repeat (20) @(negedge clk);
        model_clear();
        check_table("R10 abort table");
        check("R10 no pending verdicts", sb_q.size(), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule